// File: doc/BRIEF.md
# Binary32 to Integer Converter

This block turns an IEEE binary32 operand into a 32-bit integer, either unsigned or two's-complement signed, under one of four rounding modes. A force-toward-zero input replaces the selected mode with truncation. Besides the integer, it returns three flags: invalid (the value cannot be represented, or the operand is a NaN), inexact (discarded fraction bits were nonzero) and denormal-input (the operand was subnormal).

The block works through a small state machine. In ST_IDLE a `start` pulse captures the operand, the signedness and the effective rounding mode. The transition IDLE→ALIGN is taken on that start. In ST_ALIGN the operand is classified and shifted into an integer word and a left-aligned remainder word. ALIGN→ROUND is unconditional. ST_ROUND forms the increment, resolves saturation and the special classes, and registers the result and flags. ROUND→DONE is unconditional. ST_DONE raises `done` for one cycle, and DONE→IDLE follows. The result and flags hold until the next conversion finishes. A `start` seen outside ST_IDLE is ignored.

Top module: `f2i_convert`

## Requirements
- R1: `flag_denorm` is 1 exactly when the operand's exponent field (bits 30:23) is 0 and its fraction field (bits 22:0) is nonzero. This holds whatever the result.
- R2: A NaN operand (exponent 255, fraction nonzero) gives 0xFFFFFFFF with invalid in unsigned mode, whatever its sign bit. In signed mode it gives 0 with invalid.
- R3: A non-NaN operand with biased exponent 159 or more (this includes infinities) saturates with invalid and without inexact. Unsigned mode gives 0 for a negative operand and 0xFFFFFFFF for a positive one. Signed mode gives 0x80000000 for a negative operand and 0x7FFFFFFF for a positive one.
- R4: `rmode` selects the rounding: 0 is nearest with ties to even, 1 is toward +infinity, 2 is toward −infinity, 3 is toward zero. For exponents 126 to 158 the magnitude is rounded to an integer under this mode.
- R5: When `force_rz` is 1, the conversion truncates toward zero whatever `rmode` holds.
- R6: In unsigned mode, a negative operand whose rounded magnitude is nonzero yields 0 with invalid and without inexact.
- R7: In signed mode, a rounded magnitude above 0x7FFFFFFF (positive) or above 0x80000000 (negative) is clamped to that limit with invalid, and the result is then negated for a negative operand. So −2^31 converts exactly, with no flags.
- R8: When neither saturation nor invalid applies, inexact is 1 exactly when discarded fraction bits were nonzero. A zero operand of either sign gives 0 with no flags.
- R9: A nonzero operand with exponent below 126 gives inexact and the result 0, with these exceptions. Toward +infinity on a positive operand gives 1. Toward −infinity on a negative operand gives 0xFFFFFFFF in signed mode, and 0 with invalid in unsigned mode.
- R10: `done` is high for exactly one cycle, in the third cycle after the edge that accepted `start`. The result and flags stay constant after that until the next conversion completes.
- R11: A `start` while `busy` is 1 is ignored; the running conversion completes with its own operand.
- R12: After reset, `busy`, `done`, `result` and all flags are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| start | input | 1 | Begin a conversion (taken only when idle) |
| operand | input | 32 | Binary32 operand |
| signed_mode | input | 1 | 1: signed result, 0: unsigned result |
| rmode | input | 2 | Rounding mode: 0 nearest-even, 1 up, 2 down, 3 toward zero |
| force_rz | input | 1 | Truncate regardless of rmode |
| busy | output | 1 | Conversion in progress |
| done | output | 1 | One-cycle completion strobe |
| result | output | 32 | Converted integer |
| flag_invalid | output | 1 | Invalid-operation flag |
| flag_inexact | output | 1 | Inexact flag |
| flag_denorm | output | 1 | Subnormal-input flag |

## Verification
The bench aims at the edges between operand classes. At exponent 126 the whole value sits in the remainder, so a misplaced shift would return 1 for 0.5 under nearest-even. At exponent 158, 2^31 in signed mode must clamp while −2^31 must pass exactly; an off-by-one clamp limit would flag the negative case or wrap the positive one. Ties such as 1.5 and 2.5 expose a wrong even-bit test, and small negative values in unsigned mode show whether the invalid and inexact rules are applied in the right order. NaNs of both signs, infinities, subnormals under directed rounding, and a start pulse issued while busy cover the remaining rules. All of these are mixed with seeded random operands concentrated near the in-range exponents.

// File: rtl/f2i_pkg.sv
`timescale 1ns/1ps
package f2i_pkg;
    localparam int EXP_W  = 8;
    localparam int MAN_W  = 23;
    localparam int INT_W  = 32;
    localparam int BIAS   = (1 << (EXP_W - 1)) - 1;
    localparam int EXP_LO = BIAS - 1;          // lowest exponent with integer path
    localparam int EXP_HI = BIAS + INT_W;      // first saturating exponent
    localparam int PAD_W  = INT_W - 2 - MAN_W; // zero bits below the fraction
    localparam int SH_W   = $clog2(INT_W + 1);

    typedef enum logic [1:0] {
        RM_NEAR = 2'd0,
        RM_UP   = 2'd1,
        RM_DOWN = 2'd2,
        RM_ZERO = 2'd3
    } rmode_t;

    typedef enum logic [2:0] {
        CL_ZERO,
        CL_TINY,
        CL_RANGE,
        CL_HUGE,
        CL_NAN
    } class_t;

    typedef enum logic [1:0] {
        ST_IDLE,
        ST_ALIGN,
        ST_ROUND,
        ST_DONE
    } state_t;

    typedef struct packed {
        logic             sign;
        logic [EXP_W-1:0] exp;
        logic [INT_W-1:0] sig;
        class_t           cls;
        logic             denorm;
    } fields_t;
endpackage

// File: rtl/f2i_unpack.sv
`timescale 1ns/1ps
module f2i_unpack
    import f2i_pkg::*;
(
    input  logic [INT_W-1:0] word,
    output fields_t          fld
);
    logic [EXP_W-1:0] e;
    logic [MAN_W-1:0] frac;
    logic             e_max, e_min, f_nz;

    assign e     = word[INT_W-2 -: EXP_W];
    assign frac  = word[MAN_W-1:0];
    assign e_max = (e == {EXP_W{1'b1}});
    assign e_min = (e == '0);
    assign f_nz  = (frac != '0);

    always_comb begin
        fld.sign   = word[INT_W-1];
        fld.exp    = e;
        fld.sig    = {1'b0, ~e_min, frac, {PAD_W{1'b0}}};
        fld.denorm = e_min && f_nz;
        if (e_max && f_nz)
            fld.cls = CL_NAN;
        else if (int'(e) >= EXP_HI)
            fld.cls = CL_HUGE;
        else if (e_min && !f_nz)
            fld.cls = CL_ZERO;
        else if (int'(e) < EXP_LO)
            fld.cls = CL_TINY;
        else
            fld.cls = CL_RANGE;
    end
endmodule

// File: rtl/f2i_align.sv
`timescale 1ns/1ps
module f2i_align
    import f2i_pkg::*;
(
    input  logic [EXP_W-1:0] exp,
    input  logic [INT_W-1:0] sig,
    output logic [INT_W-1:0] ipart,
    output logic [INT_W-1:0] rem
);
    logic [SH_W-1:0]    shamt;
    logic [2*INT_W-1:0] wide;

    always_comb begin
        if (int'(exp) < EXP_LO)
            shamt = SH_W'(INT_W);
        else if (int'(exp) > EXP_HI - 1)
            shamt = '0;
        else
            shamt = SH_W'((EXP_HI - 1) - int'(exp));
        wide  = {sig[INT_W-2:0], 1'b0, {INT_W{1'b0}}} >> shamt;
        ipart = wide[2*INT_W-1:INT_W];
        rem   = wide[INT_W-1:0];
    end
endmodule

// File: rtl/f2i_round.sv
`timescale 1ns/1ps
module f2i_round
    import f2i_pkg::*;
(
    input  logic [INT_W-1:0] ipart,
    input  logic [INT_W-1:0] rem,
    input  logic             sign,
    input  rmode_t           rm,
    input  logic             is_signed,
    output logic [INT_W-1:0] value,
    output logic             invalid,
    output logic             inexact
);
    logic [INT_W-1:0] incr, bumped, mag, lim;
    logic [INT_W:0]   sum;
    logic             carry, at_top, wrap;

    always_comb begin
        unique case (rm)
            RM_NEAR: incr = ipart[0] ? {1'b1, {(INT_W-1){1'b0}}}
                                     : {1'b0, {(INT_W-1){1'b1}}};
            RM_UP:   incr = sign ? '0 : '1;
            RM_DOWN: incr = sign ? '1 : '0;
            RM_ZERO: incr = '0;
            default: incr = '0;
        endcase
        sum    = {1'b0, rem} + {1'b0, incr};
        carry  = sum[INT_W];
        at_top = (ipart == '1);
        wrap   = carry && at_top && !is_signed;
        bumped = ipart + INT_W'(carry && !at_top);
        lim    = sign ? {1'b1, {(INT_W-1){1'b0}}} : {1'b0, {(INT_W-1){1'b1}}};
        mag    = bumped;
        value  = '0;
        invalid = 1'b0;
        inexact = 1'b0;
        if (is_signed) begin
            if (bumped > lim) begin
                mag     = lim;
                invalid = 1'b1;
            end else begin
                inexact = (rem != '0);
            end
            value = sign ? (~mag + 1'b1) : mag;
        end else begin
            if (sign && bumped != '0) begin
                invalid = 1'b1;
            end else begin
                value   = bumped;
                invalid = wrap;
                inexact = (rem != '0) && !wrap;
            end
        end
    end
endmodule

// File: rtl/f2i_convert.sv
`timescale 1ns/1ps
module f2i_convert
    import f2i_pkg::*;
(
    input  logic             clk,
    input  logic             rst_n,
    input  logic             start,
    input  logic [31:0]      operand,
    input  logic             signed_mode,
    input  logic [1:0]       rmode,
    input  logic             force_rz,
    output logic             busy,
    output logic             done,
    output logic [31:0]      result,
    output logic             flag_invalid,
    output logic             flag_inexact,
    output logic             flag_denorm
);
    state_t           state, state_nxt;
    logic [INT_W-1:0] op_q;
    logic             signed_q;
    rmode_t           rm_q;
    fields_t          fld;
    logic [INT_W-1:0] ipart_c, rem_c, ipart_q, rem_q;
    class_t           cls_q;
    logic             sign_q, den_q;
    logic [INT_W-1:0] rnd_val, nxt_res;
    logic             rnd_inv, rnd_inx, nxt_inv, nxt_inx;
    logic             accept;

    assign busy   = (state != ST_IDLE);
    assign done   = (state == ST_DONE);
    assign accept = start && (state == ST_IDLE);

    f2i_unpack u_unpack (.word(op_q), .fld(fld));

    f2i_align u_align (
        .exp   (fld.exp),
        .sig   (fld.sig),
        .ipart (ipart_c),
        .rem   (rem_c)
    );

    f2i_round u_round (
        .ipart     (ipart_q),
        .rem       (rem_q),
        .sign      (sign_q),
        .rm        (rm_q),
        .is_signed (signed_q),
        .value     (rnd_val),
        .invalid   (rnd_inv),
        .inexact   (rnd_inx)
    );

    // state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state <= ST_IDLE;
        else        state <= state_nxt;
    end

    always_comb begin
        state_nxt = state;
        unique case (state)
            ST_IDLE:  if (start) state_nxt = ST_ALIGN;
            ST_ALIGN: state_nxt = ST_ROUND;
            ST_ROUND: state_nxt = ST_DONE;
            ST_DONE:  state_nxt = ST_IDLE;
            default:  state_nxt = ST_IDLE;
        endcase
    end

    // operand capture and alignment registers
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            op_q     <= '0;
            signed_q <= 1'b0;
            rm_q     <= RM_NEAR;
            ipart_q  <= '0;
            rem_q    <= '0;
            cls_q    <= CL_ZERO;
            sign_q   <= 1'b0;
            den_q    <= 1'b0;
        end else begin
            if (accept) begin
                op_q     <= operand;
                signed_q <= signed_mode;
                rm_q     <= force_rz ? RM_ZERO : rmode_t'(rmode);
            end
            if (state == ST_ALIGN) begin
                ipart_q <= ipart_c;
                rem_q   <= rem_c;
                cls_q   <= fld.cls;
                sign_q  <= fld.sign;
                den_q   <= fld.denorm;
            end
        end
    end

    // class resolution
    always_comb begin
        nxt_res = '0;
        nxt_inv = 1'b0;
        nxt_inx = 1'b0;
        unique case (cls_q)
            CL_NAN: begin
                nxt_res = signed_q ? '0 : '1;
                nxt_inv = 1'b1;
            end
            CL_HUGE: begin
                if (signed_q)
                    nxt_res = sign_q ? {1'b1, {(INT_W-1){1'b0}}}
                                     : {1'b0, {(INT_W-1){1'b1}}};
                else
                    nxt_res = sign_q ? '0 : '1;
                nxt_inv = 1'b1;
            end
            CL_ZERO: nxt_res = '0;
            CL_TINY: begin
                nxt_inx = 1'b1;
                if (rm_q == RM_UP && !sign_q)
                    nxt_res = INT_W'(1);
                else if (rm_q == RM_DOWN && sign_q) begin
                    if (signed_q) nxt_res = '1;
                    else          nxt_inv = 1'b1;
                end
            end
            CL_RANGE: begin
                nxt_res = rnd_val;
                nxt_inv = rnd_inv;
                nxt_inx = rnd_inx;
            end
            default: nxt_res = '0;
        endcase
    end

    // output registers
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            result       <= '0;
            flag_invalid <= 1'b0;
            flag_inexact <= 1'b0;
            flag_denorm  <= 1'b0;
        end else if (state == ST_ROUND) begin
            result       <= nxt_res;
            flag_invalid <= nxt_inv;
            flag_inexact <= nxt_inx;
            flag_denorm  <= den_q;
        end
    end

    // checks
    logic op_nan, op_big;
    assign op_nan = (op_q[INT_W-2 -: EXP_W] == '1) && (op_q[MAN_W-1:0] != '0);
    assign op_big = int'(op_q[INT_W-2 -: EXP_W]) >= EXP_HI;

    a_r10_done_pulse: assert property (@(posedge clk) disable iff (!rst_n)
        done |=> !done);
    a_r10_latency: assert property (@(posedge clk) disable iff (!rst_n)
        (start && !busy) |=> ##2 done);
    a_r11_busy_ignore: assert property (@(posedge clk) disable iff (!rst_n)
        (start && busy) |=> $stable(op_q));
    a_r1_denorm: assert property (@(posedge clk) disable iff (!rst_n)
        done |-> (flag_denorm == ((op_q[INT_W-2 -: EXP_W] == '0) && (op_q[MAN_W-1:0] != '0))));
    a_r2_nan_unsigned: assert property (@(posedge clk) disable iff (!rst_n)
        (done && op_nan && !signed_q) |-> (result == '1 && flag_invalid));
    a_r3_huge_positive: assert property (@(posedge clk) disable iff (!rst_n)
        (done && op_big && !op_nan && !op_q[INT_W-1] && !signed_q) |-> (result == '1 && flag_invalid && !flag_inexact));
    a_r7_signed_clamp: assert property (@(posedge clk) disable iff (!rst_n)
        (done && signed_q && flag_invalid && !op_nan && !op_q[INT_W-1]) |-> (result == {1'b0, {(INT_W-1){1'b1}}}));
    a_r8_zero: assert property (@(posedge clk) disable iff (!rst_n)
        (done && op_q[INT_W-2:0] == '0) |-> (result == '0 && !flag_invalid && !flag_inexact));
endmodule

// File: tb/sim_f2i_convert.sv
`timescale 1ns/1ps
module sim_f2i_convert;
    logic        clk = 1'b0, rst_n = 1'b0, start = 1'b0;
    logic        signed_mode = 1'b0, force_rz = 1'b0;
    logic [1:0]  rmode = 2'd0;
    logic [31:0] operand = '0;
    logic        busy, done, flag_invalid, flag_inexact, flag_denorm;
    logic [31:0] result;
    int total = 0, bad = 0;
    bit finished = 1'b0;

    always #4 clk = ~clk;

    f2i_convert u0 (
        .clk(clk), .rst_n(rst_n), .start(start), .operand(operand),
        .signed_mode(signed_mode), .rmode(rmode), .force_rz(force_rz),
        .busy(busy), .done(done), .result(result),
        .flag_invalid(flag_invalid), .flag_inexact(flag_inexact),
        .flag_denorm(flag_denorm)
    );

    // {result, invalid, inexact, denorm}
    function automatic logic [34:0] ref_conv(input logic [31:0] op, input bit sg,
                                             input logic [1:0] rm0, input bit frz);
        logic s; logic [7:0] e; logic [22:0] m; logic [1:0] rm;
        logic [31:0] res; logic inv, inx, den;
        logic [63:0] big, mag, frac, half, lim; bit up; int k;
        s = op[31]; e = op[30:23]; m = op[22:0];
        rm = frz ? 2'd3 : rm0;
        den = (e == 0) && (m != 0);
        res = 0; inv = 0; inx = 0;
        if (e == 8'hFF && m != 0) begin
            res = sg ? 32'h0 : 32'hFFFFFFFF; inv = 1;
        end else if (e >= 159) begin
            if (sg) res = s ? 32'h80000000 : 32'h7FFFFFFF;
            else    res = s ? 32'h0 : 32'hFFFFFFFF;
            inv = 1;
        end else if (e == 0 && m == 0) begin
            res = 0;
        end else if (e < 126) begin
            inx = 1;
            if (rm == 2'd1 && !s) res = 1;
            else if (rm == 2'd2 && s) begin
                if (sg) res = 32'hFFFFFFFF; else inv = 1;
            end
        end else begin
            big = {40'd1, m};
            if (e >= 150) begin
                mag = big << (e - 150); frac = 0; half = 0;
            end else begin
                k = 150 - int'(e);
                mag = big >> k;
                frac = big & ((64'd1 << k) - 1);
                half = 64'd1 << (k - 1);
            end
            case (rm)
                2'd0: up = (frac > half) || (frac == half && frac != 0 && mag[0]);
                2'd1: up = (frac != 0) && !s;
                2'd2: up = (frac != 0) && s;
                default: up = 0;
            endcase
            mag = mag + (up ? 64'd1 : 64'd0);
            if (sg) begin
                lim = s ? 64'h80000000 : 64'h7FFFFFFF;
                if (mag > lim) begin res = lim[31:0]; inv = 1; end
                else begin res = s ? (~mag[31:0] + 1) : mag[31:0]; inx = (frac != 0); end
            end else begin
                if (s && mag != 0) begin res = 0; inv = 1; end
                else begin res = mag[31:0]; inx = (frac != 0); end
            end
        end
        return {res, inv, inx, den};
    endfunction

    task automatic check_val(input string tag, input logic [34:0] act, input logic [34:0] exp);
        total++;
        if (act !== exp) begin
            bad++;
            $display("FAIL %s: res=%h inv=%b inx=%b den=%b expected res=%h inv=%b inx=%b den=%b",
                     tag, act[34:3], act[2], act[1], act[0], exp[34:3], exp[2], exp[1], exp[0]);
        end
    endtask

    task automatic check_int(input string tag, input int act, input int exp);
        total++;
        if (act != exp) begin
            bad++;
            $display("FAIL %s: actual=%0d expected=%0d", tag, act, exp);
        end
    endtask

    // drives a start, optionally a second start while busy, checks latency and outputs
    task automatic run_op(input logic [31:0] op, input bit sg, input logic [1:0] rm,
                          input bit frz, input string tag, input bit poke_busy);
        int lat;
        logic [34:0] exp;
        exp = ref_conv(op, sg, rm, frz);
        @(negedge clk);
        operand = op; signed_mode = sg; rmode = rm; force_rz = frz; start = 1'b1;
        @(negedge clk);
        lat = 1;
        if (poke_busy) begin
            operand = ~op; signed_mode = ~sg; rmode = ~rm; force_rz = 1'b0; // R11 ignored start
            @(negedge clk);
            lat = 2;
        end
        start = 1'b0;
        while (!done && lat < 8) begin
            @(negedge clk);
            lat++;
        end
        check_int({tag, " R10 latency"}, lat, 3);
        check_val(tag, {result, flag_invalid, flag_inexact, flag_denorm}, exp);
    endtask

    initial begin
        #1600000;
        if (!finished) begin
            total++; bad++;
            $display("FAIL watchdog: run did not complete");
            $display("  test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end

    initial begin
        logic [31:0] op;
        logic [34:0] held;
        void'($urandom(32'h5EED1234));
        repeat (3) @(negedge clk);
        // R12 reset state
        check_val("R12 reset", {result, flag_invalid, flag_inexact, flag_denorm}, 35'd0);
        check_int("R12 busy/done", {30'd0, busy, done}, 0);
        rst_n = 1'b1;
        @(negedge clk);

        // R4 rounding modes and ties
        run_op(32'h3FC00000, 0, 2'd0, 0, "R4 1.5 nearest", 0);
        run_op(32'h40200000, 0, 2'd0, 0, "R4 2.5 nearest", 0);
        run_op(32'h40200000, 0, 2'd1, 0, "R4 2.5 up", 0);
        run_op(32'h40200000, 1, 2'd2, 0, "R4 2.5 down", 0);
        run_op(32'hC0200000, 1, 2'd2, 0, "R4 -2.5 down", 0);
        run_op(32'h3F000000, 0, 2'd0, 0, "R4 0.5 exp126 tie", 0);
        run_op(32'h3F400000, 1, 2'd0, 0, "R4 0.75 exp126", 0);
        // R5 force toward zero
        run_op(32'h402CCCCD, 0, 2'd0, 1, "R5 2.7 forced", 0);
        run_op(32'hC02CCCCD, 1, 2'd2, 1, "R5 -2.7 forced", 0);
        // R6 unsigned negative
        run_op(32'hC0200000, 0, 2'd0, 0, "R6 -2.5 unsigned", 0);
        run_op(32'hBF19999A, 0, 2'd3, 0, "R6 -0.6 unsigned trunc", 0);
        run_op(32'hBF19999A, 0, 2'd0, 0, "R6 -0.6 unsigned nearest", 0);
        // R2 NaN
        run_op(32'h7FC00000, 0, 2'd0, 0, "R2 qnan unsigned", 0);
        run_op(32'hFF800001, 0, 2'd1, 0, "R2 neg snan unsigned", 0);
        run_op(32'h7FC00000, 1, 2'd0, 0, "R2 qnan signed", 0);
        // R3 saturation
        run_op(32'h7F800000, 1, 2'd0, 0, "R3 +inf signed", 0);
        run_op(32'hFF800000, 0, 2'd0, 0, "R3 -inf unsigned", 0);
        run_op(32'hFF800000, 1, 2'd0, 0, "R3 -inf signed", 0);
        run_op(32'h4F800000, 0, 2'd0, 0, "R3 2^32 unsigned", 0);
        // R7 signed clamp
        run_op(32'h4F000000, 1, 2'd0, 0, "R7 2^31 signed", 0);
        run_op(32'hCF000000, 1, 2'd0, 0, "R7 -2^31 signed exact", 0);
        run_op(32'hCF000001, 1, 2'd0, 0, "R7 below -2^31", 0);
        run_op(32'h4F7FFFFF, 0, 2'd1, 0, "R8 max unsigned exact", 0);
        // R8 zeros
        run_op(32'h00000000, 1, 2'd1, 0, "R8 +0", 0);
        run_op(32'h80000000, 0, 2'd2, 0, "R8 -0", 0);
        // R9 tiny and R1 denormal
        run_op(32'h3E800000, 0, 2'd1, 0, "R9 0.25 up", 0);
        run_op(32'hBE800000, 1, 2'd2, 0, "R9 -0.25 down signed", 0);
        run_op(32'hBE800000, 0, 2'd2, 0, "R9 -0.25 down unsigned", 0);
        run_op(32'h3E800000, 1, 2'd0, 0, "R9 0.25 nearest", 0);
        run_op(32'h00000001, 0, 2'd0, 0, "R1 denormal", 0);
        run_op(32'h00400000, 1, 2'd1, 0, "R1 denormal up", 0);
        run_op(32'h80000005, 1, 2'd2, 0, "R1 neg denormal down", 0);
        // R11 start while busy
        run_op(32'h41200000, 1, 2'd0, 0, "R11 busy start", 1);
        // R10 hold after done
        held = {result, flag_invalid, flag_inexact, flag_denorm};
        repeat (3) @(negedge clk);
        check_val("R10 held", {result, flag_invalid, flag_inexact, flag_denorm}, held);

        // random mix
        for (int i = 0; i < 3000; i++) begin
            op = $urandom;
            if ($urandom % 3 != 0) op[30:23] = 8'(120 + ($urandom % 46));
            run_op(op, bit'($urandom % 2), 2'($urandom % 4), ($urandom % 8) == 0,
                   "R4 random", ($urandom % 16) == 0);
        end

        finished = 1'b1;
        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    end
endmodule